// File: doc/BRIEF.md
# Range-Switch Settle and Discard Sequencer

This block sits on the output sample stream of one measurement channel. The channel can move between multiplexer inputs and between measurement ranges, and each such move disturbs the signal. When a switch request arrives, the block drives the new selection to the front-end at once. It then waits through a programmable number of clock cycles so the analog path can recover. After that it throws away a programmable number of converter or decimator output samples so the digital filter memory is flushed. Only then does it let samples through, each one marked as qualified.

The converter can also raise a single-bit over-range flag. This flag runs the same recovery sequence but leaves the selection where it is. A new request or a new over-range flag that arrives while a sequence is still running cancels it and starts a fresh sequence. A busy output tells the surrounding logic that the channel is not yet reporting. The front-end itself, the converter and the filter arithmetic are not part of this block.

Top module: `switch_settle_gate`

## Requirements
- R1: After reset, selOut is 0, outValid is 0 and busy is 0, and the block passes samples straight through: a strobe sampled after reset appears on outValid one cycle later, carrying its data.
- R2: When switchReq is high at a clock edge, selOut takes the value of newSel at that edge. selOut changes at no other time.
- R3: A sample strobe that coincides with a request cycle (switchReq or overRange high) is dropped. Strobes in the settleCycles clock cycles that follow the request cycle are neither forwarded nor counted.
- R4: Once the settle window has ended, the first discardCount strobes are dropped and the next strobe is forwarded. The discard count goes down only on sampleValid strobes, never on idle cycles.
- R5: A forwarded sample shows outValid high in the cycle after its strobe, with outData equal to the sampled data. Once the sequence has completed, every strobe is forwarded. outValid is low in every other cycle.
- R6: busy is high from the cycle after a request until the cycle in which the first qualified sample appears on outValid, and it falls in that same cycle.
- R7: A request that arrives during settle or discard cancels the running sequence and restarts it with the new selection and the new counts.
- R8: settleCycles and discardCount are captured at the request edge. Changing them later does not affect the sequence already running.
- R9: overRange high at an edge starts the same settle and discard sequence without changing selOut.
- R10: With settleCycles = 0 and discardCount = 0, the first strobe after the request cycle is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| switchReq | input | 1 | Request to move to newSel |
| newSel | input | SEL_W | Requested range or channel code |
| overRange | input | 1 | Converter over-range flag; starts recovery |
| settleCycles | input | SETTLE_W | Settle window length in clock cycles |
| discardCount | input | DISCARD_W | Number of samples to drop after settling |
| sampleValid | input | 1 | Converter output strobe |
| sampleData | input | DATA_W | Converter output value |
| selOut | output | SEL_W | Range or channel select driven to the front-end |
| outValid | output | 1 | Qualified sample strobe |
| outData | output | DATA_W | Qualified sample value |
| busy | output | 1 | Sequence in progress, no qualified output yet |

## Verification
The bench targets the edge between the two gates. It uses sparse strobes that straddle the end of the settle window. A design that counted discards on idle cycles, or began counting one cycle early, would forward the wrong sample number.

A second request fired in the middle of a settle window checks that the old counts are abandoned. A design that did not restart would qualify data from the old selection.

The bench also changes the count inputs right after a request. A design that read those inputs live instead of capturing them would stretch or shorten the sequence.

An over-range pulse is driven with a different value on newSel. This exposes a design that reloads the selection on recovery.

// File: rtl/settle_gate_pkg.sv
package settle_gate_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_DISCARD = 2'd2
  } gateState_e;

  typedef struct packed {
    logic loadSel;
    logic forward;
  } gateStrobe_t;

endpackage

// File: rtl/settle_gate_downcnt.sv
module settle_gate_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         dec,
  output logic [W-1:0] value
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= '0;
    end else if (load) begin
      value <= loadVal;
    end else if (dec && (value != '0)) begin
      value <= value - W'(1);
    end
  end

endmodule

// File: rtl/settle_gate_ctrl.sv
module settle_gate_ctrl
  import settle_gate_pkg::*;
#(
  parameter int SETTLE_W  = 16,
  parameter int DISCARD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 switchReq,
  input  logic                 overRange,
  input  logic [SETTLE_W-1:0]  settleCycles,
  input  logic [DISCARD_W-1:0] discardCount,
  input  logic                 sampleValid,
  output gateStrobe_t          strobes,
  output logic                 busy
);

  gateState_e state, stateNext;
  logic trigger;
  logic [SETTLE_W-1:0]  settleLeft;
  logic [DISCARD_W-1:0] discardLeft;
  logic settleDec, discardDec, discardDone, settleLast;

  assign trigger     = switchReq | overRange;
  assign discardDone = (discardLeft == '0);
  assign settleLast  = (settleLeft <= SETTLE_W'(1));
  assign settleDec   = !trigger && (state == ST_SETTLE);
  assign discardDec  = !trigger && (state == ST_DISCARD) && sampleValid && !discardDone;

  settle_gate_downcnt #(.W(SETTLE_W)) u_settleCnt (
    .clk     (clk),
    .rstN    (rstN),
    .load    (trigger),
    .loadVal (settleCycles),
    .dec     (settleDec),
    .value   (settleLeft)
  );

  settle_gate_downcnt #(.W(DISCARD_W)) u_discardCnt (
    .clk     (clk),
    .rstN    (rstN),
    .load    (trigger),
    .loadVal (discardCount),
    .dec     (discardDec),
    .value   (discardLeft)
  );

  always_comb begin
    stateNext = state;
    if (trigger) begin
      stateNext = (settleCycles == '0) ? ST_DISCARD : ST_SETTLE;
    end else begin
      unique case (state)
        ST_SETTLE:  if (settleLast) stateNext = ST_DISCARD;
        ST_DISCARD: if (sampleValid && discardDone) stateNext = ST_RUN;
        default:    stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.loadSel = switchReq;
    strobes.forward = !trigger && sampleValid &&
                      ((state == ST_RUN) || ((state == ST_DISCARD) && discardDone));
  end

  assign busy = (state != ST_RUN);

endmodule

// File: rtl/settle_gate_dpath.sv
module settle_gate_dpath
  import settle_gate_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int DATA_W    = 16,
  parameter logic [SEL_W-1:0] RESET_SEL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobes,
  input  logic [SEL_W-1:0]  newSel,
  input  logic [DATA_W-1:0] sampleData,
  output logic [SEL_W-1:0]  selOut,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selOut <= RESET_SEL;
    end else if (strobes.loadSel) begin
      selOut <= newSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobes.forward;
      if (strobes.forward) outData <= sampleData;
    end
  end

endmodule

// File: rtl/switch_settle_gate.sv
module switch_settle_gate
  import settle_gate_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int DATA_W    = 16,
  parameter int SETTLE_W  = 16,
  parameter int DISCARD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 switchReq,
  input  logic [SEL_W-1:0]     newSel,
  input  logic                 overRange,
  input  logic [SETTLE_W-1:0]  settleCycles,
  input  logic [DISCARD_W-1:0] discardCount,
  input  logic                 sampleValid,
  input  logic [DATA_W-1:0]    sampleData,
  output logic [SEL_W-1:0]     selOut,
  output logic                 outValid,
  output logic [DATA_W-1:0]    outData,
  output logic                 busy
);

  gateStrobe_t strobes;

  settle_gate_ctrl #(.SETTLE_W(SETTLE_W), .DISCARD_W(DISCARD_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .switchReq    (switchReq),
    .overRange    (overRange),
    .settleCycles (settleCycles),
    .discardCount (discardCount),
    .sampleValid  (sampleValid),
    .strobes      (strobes),
    .busy         (busy)
  );

  settle_gate_dpath #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .newSel     (newSel),
    .sampleData (sampleData),
    .selOut     (selOut),
    .outValid   (outValid),
    .outData    (outData)
  );

endmodule

// File: rtl/settle_gate_chk.sv
module settle_gate_chk #(
  parameter int SEL_W  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              switchReq,
  input logic [SEL_W-1:0]  newSel,
  input logic              overRange,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleData,
  input logic [SEL_W-1:0]  selOut,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              busy
);

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    switchReq |=> (selOut == $past(newSel))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !switchReq |=> $stable(selOut)); // R9
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (switchReq || overRange) |=> !outValid); // R3
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (switchReq || overRange) |=> busy); // R6
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> outValid); // R6
  AST_VALID_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid)); // R5
  AST_DATA_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData == $past(sampleData))); // R5
  AST_RUN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && sampleValid && !switchReq && !overRange) |=> outValid); // R5

endmodule

bind switch_settle_gate settle_gate_chk #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .switchReq   (switchReq),
  .newSel      (newSel),
  .overRange   (overRange),
  .sampleValid (sampleValid),
  .sampleData  (sampleData),
  .selOut      (selOut),
  .outValid    (outValid),
  .outData     (outData),
  .busy        (busy)
);

// File: tb/tb_switch_settle_gate.sv
module tb_switch_settle_gate;

  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 4, DATA_W = 16, SETTLE_W = 16, DISCARD_W = 8;
  localparam int WIN = 40;
  localparam int NVEC = 8;
  // settle, discard, strobe gap, select, expected first forwarded cycle index
  localparam int VEC [NVEC][5] = '{
    '{0, 0, 1, 3, 1},   // R10
    '{5, 0, 1, 7, 6},   // R3
    '{0, 4, 1, 12, 5},  // R4
    '{3, 2, 1, 1, 6},   // R3 R4
    '{4, 2, 3, 6, 13},  // R4 gaps
    '{10, 1, 2, 15, 13},
    '{2, 3, 4, 2, 17},
    '{7, 0, 5, 10, 11}
  };

  logic clk = 0, rstN = 0, switchReq = 0, overRange = 0, sampleValid = 0;
  logic [SEL_W-1:0] newSel = '0;
  logic [SETTLE_W-1:0] settleCycles = '0;
  logic [DISCARD_W-1:0] discardCount = '0;
  logic [DATA_W-1:0] sampleData = '0;
  logic [SEL_W-1:0] selOut;
  logic outValid, busy;
  logic [DATA_W-1:0] outData;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  switch_settle_gate #(.SEL_W(SEL_W), .DATA_W(DATA_W), .SETTLE_W(SETTLE_W),
                       .DISCARD_W(DISCARD_W)) dut (
    .clk(clk), .rstN(rstN), .switchReq(switchReq), .newSel(newSel),
    .overRange(overRange), .settleCycles(settleCycles), .discardCount(discardCount),
    .sampleValid(sampleValid), .sampleData(sampleData), .selOut(selOut),
    .outValid(outValid), .outData(outData), .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runSeq(input int s, input int d, input int gap, input int sel,
                        input int expFirst, input bit useOvr, input int expSel,
                        input bit scramble, input string tag);
    int first = 0, firstData = 0, fwd = 0, expFwd = 0;
    bit busyOk = 1;
    @(negedge clk);
    settleCycles = SETTLE_W'(s); discardCount = DISCARD_W'(d); newSel = SEL_W'(sel);
    switchReq = !useOvr; overRange = useOvr; sampleValid = 0;
    @(negedge clk);
    switchReq = 0; overRange = 0;
    if (scramble) begin settleCycles = 20; discardCount = 10; end
    check(busy == 1'b1, "R6 busy after request", int'(busy), 1);
    check(selOut == SEL_W'(expSel), {tag, " R2 selOut"}, int'(selOut), expSel);
    for (int j = 1; j <= WIN; j++) begin
      sampleValid = ((j - 1) % gap) == 0;
      sampleData = DATA_W'(j);
      if (sampleValid && j >= expFirst) expFwd++;
      @(negedge clk);
      if (outValid) begin
        if (first == 0) begin
          first = j; firstData = int'(outData);
          if (busy) busyOk = 0;
        end
        fwd++;
      end else if (first == 0 && !busy) busyOk = 0;
    end
    sampleValid = 0;
    check(first == expFirst, {tag, " first qualified cycle"}, first, expFirst);
    check(firstData == expFirst, {tag, " R5 first data"}, firstData, expFirst);
    check(busyOk, {tag, " R6 busy until first"}, int'(busyOk), 1);
    check(fwd == expFwd, {tag, " R5 forwarded count"}, fwd, expFwd);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state and pass-through
    check(selOut == '0, "R1 selOut reset", int'(selOut), 0);
    check(outValid == 1'b0, "R1 outValid reset", int'(outValid), 0);
    check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    sampleValid = 1; sampleData = 16'd77;
    @(negedge clk);
    sampleValid = 0;
    check(outValid && outData == 16'd77, "R1 pass-through after reset", int'(outData), 77);

    // Vector table: R3 R4 R5 R6 R10
    for (int v = 0; v < NVEC; v++)
      runSeq(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0,
             VEC[v][3], 1'b0, $sformatf("R3/R4 vec%0d", v));

    // R9 over-range keeps selection (newSel differs)
    runSeq(2, 1, 1, 5, 4, 1'b1, 10, 1'b0, "R9 over-range");

    // R8 counts captured at request
    runSeq(3, 1, 1, 4, 5, 1'b0, 4, 1'b1, "R8 latched counts");

    // R7 restart mid-settle
    @(negedge clk);
    settleCycles = 6; discardCount = 2; newSel = 5; switchReq = 1;
    @(negedge clk);
    switchReq = 0;
    first = 0;
    for (int j = 1; j <= 15; j++) begin
      sampleValid = 1; sampleData = DATA_W'(j);
      if (j == 4) begin
        switchReq = 1; newSel = 9; settleCycles = 2; discardCount = 1;
      end else switchReq = 0;
      @(negedge clk);
      if (outValid && first == 0) first = j;
    end
    sampleValid = 0; switchReq = 0;
    check(first == 8, "R7 restart first qualified", first, 8);
    check(selOut == 4'd9, "R7 restart selection", int'(selOut), 9);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule